// File: doc/BRIEF.md
# Multiline Serial Port Register Bank

This block is the register bank that a host sees for an eight-line asynchronous serial multiplexer. It sits on a simple synchronous register bus. A word at offset 0 combines status flags, the two interrupt enables, a self-clearing master clear and a five-bit indirect pointer. Offset 1 is where line parameters are written. The line they apply to is carried in the low bits of the written data. Offset 2 is a shared indirect data word. The indirect pointer picks which line and which register group appear through it.

The pointer has two fields. Its low three bits select a line. Its upper two bits select a group: 0 gives transmit data and modem input status, 1 gives line control and the modem output byte, and 2 and 3 are the transmit address and count groups. The block stores line parameters, line control and modem output bits for every line. It drives them on flat output vectors for the serializers, which are separate blocks. Transmit data written through group 0 goes out as a one-cycle strobe. A silo-flush request goes out as a one-cycle pulse for one line.

Top module: `serial_mux_regbank`

## Requirements
- R1: After reset, all stored fields, both interrupt enables, the pointer and every output are 0. With the status inputs low, offset 0 reads 0.
- R2: Offset 0 reads as follows: bit 15 tx_pend_i, bit 14 transmit interrupt enable, bit 13 nxm_i, bits 10:8 tx_line_i, bit 7 rx_pend_i, bit 6 receive interrupt enable, bit 5 master clear, bits 4:0 pointer. Every other bit reads 0. Byte strobe 0 writes bits 6:0. Byte strobe 1 writes bit 14. The status bits ignore writes.
- R3: Writing offset 0 with bit 5 set makes bit 5 read 1 for exactly the next cycle. At the end of that cycle every per-line field and both enables are cleared, and bit 5 returns to 0. The pointer is kept. Bus writes in that cycle are discarded.
- R4: A write to offset 1 selects line wdata[2:0]. Strobe 0 stores wdata[7:3] and strobe 1 stores wdata[15:8]. Each line presents 13 bits on lpr_o[13*l +: 13]: bits 1:0 character length, bit 2 parity enable, bit 3 odd parity, bit 4 two stop bits, bits 8:5 receive speed, bits 12:9 transmit speed. Offset 1 reads the pointer's line as {13 stored bits, line number}.
- R5: In group 1, strobe 0 stores bits 5 and 3:0 into the line control byte (lcr_o[6*l +: 6]). Bits 7:6 are ignored and bit 4 reads 0. Writing bit 4 as 1 raises flush_o[line] for the single cycle after the write.
- R6: In group 1, strobe 1 stores wdata[12:8] as the line's modem output bits (tms_o[5*l +: 5]). Group 1 reads {3'b0, modem bits, 2'b0, control byte}.
- R7: An indirect write changes only the byte lanes that are strobed, and only for the line the pointer selects. All other lines keep their values.
- R8: Group 0 reads the selected line's modem inputs (rms_i[6*l +: 6]) in bits 15:10, zeros in bits 9:8, and its silo count (tsc_i[8*l +: 8]) in bits 7:0.
- R9: A group-0 write with strobe 0 raises txd_valid_o for exactly the next cycle, with txd_line_o set to the pointer's line and txd_data_o to wdata[7:0]. A group-0 write with only strobe 1 has no effect.
- R10: Groups 2 and 3 read 0 and writes to them change nothing.
- R11: Offset 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Word offset |
| wr_en | input | 1 | Write enable |
| be | input | 2 | Byte strobes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data (combinational) |
| tx_pend_i | input | 1 | Transmit interrupt pending |
| tx_line_i | input | 3 | Line tied to the transmit interrupt |
| nxm_i | input | 1 | Nonexistent-memory error |
| rx_pend_i | input | 1 | Receive interrupt pending |
| rms_i | input | NLINES*6 | Modem input bits per line |
| tsc_i | input | NLINES*8 | Transmit silo count per line |
| tx_ie_o | output | 1 | Transmit interrupt enable |
| rx_ie_o | output | 1 | Receive interrupt enable |
| lpr_o | output | NLINES*13 | Line parameters per line |
| lcr_o | output | NLINES*6 | Line control per line |
| tms_o | output | NLINES*5 | Modem output bits per line |
| flush_o | output | NLINES | Silo flush pulse per line |
| txd_valid_o | output | 1 | Transmit data strobe |
| txd_line_o | output | 3 | Line of the transmit data |
| txd_data_o | output | 8 | Transmit data byte |

## Verification
A wrong decode of the pointer leaves its mark on a neighbouring line's output slice, and that slice is wrong on the very next cycle. Sweeping every line with a distinct pattern, and comparing all slices after each write, therefore pins the fault to the wrong line or lane at once. A clear that lasts too long, or does not happen, shows in the single cycle after the clear write, through bit 5 and through the output vectors. The flush and transmit strobes are sampled in the one cycle in which they must be high, and again one cycle later, when they must be low.

// File: rtl/serial_mux_regbank.sv
module serial_mux_regbank #(
  parameter int NLINES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            addr,
  input  logic                  wr_en,
  input  logic [1:0]            be,
  input  logic [15:0]           wdata,
  output logic [15:0]           rdata,
  input  logic                  tx_pend_i,
  input  logic [2:0]            tx_line_i,
  input  logic                  nxm_i,
  input  logic                  rx_pend_i,
  input  logic [NLINES*6-1:0]   rms_i,
  input  logic [NLINES*8-1:0]   tsc_i,
  output logic                  tx_ie_o,
  output logic                  rx_ie_o,
  output logic [NLINES*13-1:0]  lpr_o,
  output logic [NLINES*6-1:0]   lcr_o,
  output logic [NLINES*5-1:0]   tms_o,
  output logic [NLINES-1:0]     flush_o,
  output logic                  txd_valid_o,
  output logic [2:0]            txd_line_o,
  output logic [7:0]            txd_data_o
);
  localparam int LPW = 13;

  logic       tx_ie_q, rx_ie_q, clr_q;
  logic [4:0] iad_q;
  logic [2:0] sel_line;
  logic [1:0] sel_grp;
  logic       wr_csr, wr_lpr, wr_ind;

  logic [LPW-1:0] lpr_q [NLINES];
  logic [5:0]     lcr_q [NLINES];
  logic [4:0]     tms_q [NLINES];
  logic [5:0]     rms_a [NLINES];
  logic [7:0]     tsc_a [NLINES];

  assign sel_line = iad_q[2:0];
  assign sel_grp  = iad_q[4:3];
  assign wr_csr   = wr_en && !clr_q && addr == 2'd0;
  assign wr_lpr   = wr_en && !clr_q && addr == 2'd1;
  assign wr_ind   = wr_en && !clr_q && addr == 2'd2;
  assign tx_ie_o  = tx_ie_q;
  assign rx_ie_o  = rx_ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ie_q <= 1'b0;
      rx_ie_q <= 1'b0;
      clr_q   <= 1'b0;
      iad_q   <= '0;
    end else if (clr_q) begin
      tx_ie_q <= 1'b0;
      rx_ie_q <= 1'b0;
      clr_q   <= 1'b0;
    end else if (wr_csr) begin
      if (be[0]) begin
        rx_ie_q <= wdata[6];
        clr_q   <= wdata[5];
        iad_q   <= wdata[4:0];
      end
      if (be[1]) tx_ie_q <= wdata[14];
    end
  end

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic hit_ctl;
    logic flush_q;
    assign hit_ctl = wr_ind && sel_grp == 2'd1 && sel_line == 3'(g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lpr_q[g] <= '0;
        lcr_q[g] <= '0;
        tms_q[g] <= '0;
        flush_q  <= 1'b0;
      end else if (clr_q) begin
        lpr_q[g] <= '0;
        lcr_q[g] <= '0;
        tms_q[g] <= '0;
        flush_q  <= 1'b0;
      end else begin
        if (wr_lpr && wdata[2:0] == 3'(g)) begin
          if (be[0]) lpr_q[g][4:0]  <= wdata[7:3];
          if (be[1]) lpr_q[g][12:5] <= wdata[15:8];
        end
        if (hit_ctl && be[0]) lcr_q[g] <= {wdata[5], 1'b0, wdata[3:0]};
        if (hit_ctl && be[1]) tms_q[g] <= wdata[12:8];
        flush_q <= hit_ctl && be[0] && wdata[4];
      end
    end

    assign lpr_o[g*LPW +: LPW] = lpr_q[g];
    assign lcr_o[g*6 +: 6]     = lcr_q[g];
    assign tms_o[g*5 +: 5]     = tms_q[g];
    assign flush_o[g]          = flush_q;
    assign rms_a[g]            = rms_i[g*6 +: 6];
    assign tsc_a[g]            = tsc_i[g*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_valid_o <= 1'b0;
      txd_line_o  <= '0;
      txd_data_o  <= '0;
    end else begin
      txd_valid_o <= wr_ind && sel_grp == 2'd0 && be[0];
      if (wr_ind && sel_grp == 2'd0 && be[0]) begin
        txd_line_o <= sel_line;
        txd_data_o <= wdata[7:0];
      end
    end
  end

  logic [15:0] ind_rd;
  always_comb begin
    case (sel_grp)
      2'd0:    ind_rd = {rms_a[sel_line], 2'b00, tsc_a[sel_line]};
      2'd1:    ind_rd = {3'b000, tms_q[sel_line], 2'b00, lcr_q[sel_line]};
      default: ind_rd = '0;
    endcase
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = {tx_pend_i, tx_ie_q, nxm_i, 2'b00, tx_line_i,
                        rx_pend_i, rx_ie_q, clr_q, iad_q};
      2'd1:    rdata = {lpr_q[sel_line], sel_line};
      2'd2:    rdata = ind_rd;
      default: rdata = '0;
    endcase
  end
endmodule

module serial_mux_regbank_chk #(
  parameter int NLINES = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           addr,
  input logic                 wr_en,
  input logic [1:0]           be,
  input logic                 clr_q,
  input logic                 tx_ie_o,
  input logic                 rx_ie_o,
  input logic [NLINES*13-1:0] lpr_o,
  input logic [NLINES*6-1:0]  lcr_o,
  input logic [NLINES*5-1:0]  tms_o,
  input logic [NLINES-1:0]    flush_o,
  input logic                 txd_valid_o
);
  a_r3_clr_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> !clr_q);
  a_r3_clr_wipes_state: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> (lpr_o == '0 && lcr_o == '0 && tms_o == '0 && !tx_ie_o && !rx_ie_o));
  a_r9_txd_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    txd_valid_o |-> $past(wr_en && addr == 2'd2 && be[0] && !clr_q));
  a_r5_flush_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flush_o));
  a_r7_tms_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && addr == 2'd2) && !clr_q) |=> $stable(tms_o));
  a_r4_lpr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && addr == 2'd1) && !clr_q) |=> $stable(lpr_o));
endmodule

bind serial_mux_regbank serial_mux_regbank_chk #(.NLINES(NLINES)) i_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .be(be),
  .clr_q(clr_q), .tx_ie_o(tx_ie_o), .rx_ie_o(rx_ie_o), .lpr_o(lpr_o),
  .lcr_o(lcr_o), .tms_o(tms_o), .flush_o(flush_o), .txd_valid_o(txd_valid_o)
);

// File: tb/test_serial_mux_regbank.sv
`timescale 1ns/1ps
module test_serial_mux_regbank;
  localparam int N = 8;
  logic clk = 0, rst_n = 0, wr_en = 0, tx_pend_i = 0, nxm_i = 0, rx_pend_i = 0;
  logic [1:0] addr = 0, be = 0;
  logic [15:0] wdata = 0, rdata;
  logic [2:0] tx_line_i = 0, txd_line_o;
  logic [N*6-1:0] rms_i;
  logic [N*8-1:0] tsc_i;
  logic tx_ie_o, rx_ie_o, txd_valid_o;
  logic [N*13-1:0] lpr_o;
  logic [N*6-1:0] lcr_o;
  logic [N*5-1:0] tms_o;
  logic [N-1:0] flush_o;
  logic [7:0] txd_data_o;
  int tests = 0, fails = 0;
  logic [5:0] m_lcr [N];
  logic [4:0] m_tms [N];
  logic [12:0] m_lpr [N];

  always #2.5 clk = ~clk;

  serial_mux_regbank #(.NLINES(N)) i_serial_mux_regbank (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [1:0] b, logic [15:0] d);
    @(negedge clk); addr = a; be = b; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0; be = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic check_lines(string req);
    for (int l = 0; l < N; l++) begin
      chk(req, 32'(lcr_o[l*6 +: 6]), 32'(m_lcr[l]));
      chk(req, 32'(tms_o[l*5 +: 5]), 32'(m_tms[l]));
      chk(req, 32'(lpr_o[l*13 +: 13]), 32'(m_lpr[l]));
    end
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    for (int l = 0; l < N; l++) begin
      rms_i[l*6 +: 6] = 6'(l*11 + 5);
      tsc_i[l*8 +: 8] = 8'(l*3 + 1);
      m_lcr[l] = 0; m_tms[l] = 0; m_lpr[l] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, d); chk("R1", 32'(d), 0);
    check_lines("R1");
    chk("R1", {flush_o, txd_valid_o, tx_ie_o, rx_ie_o}, 0);

    // R2 control/status layout and byte lanes
    tx_pend_i = 1; nxm_i = 1; tx_line_i = 5; rx_pend_i = 1;
    wr(2'd0, 2'b11, 16'hFFDF);
    rd(2'd0, d); chk("R2", 32'(d), 32'hE5DF);
    chk("R2", {tx_ie_o, rx_ie_o}, 2'b11);
    tx_pend_i = 0; nxm_i = 0; tx_line_i = 0; rx_pend_i = 0;
    wr(2'd0, 2'b11, 16'h0000);
    rd(2'd0, d); chk("R2", 32'(d), 0);
    wr(2'd0, 2'b01, 16'h4040);
    rd(2'd0, d); chk("R2", 32'(d), 32'h0040);

    // R5 R6 sweep group 1 across lines
    for (int l = 0; l < N; l++) begin
      logic [7:0] lc, tm;
      lc = 8'(l*13 + 8'hC5); tm = 8'(l*29 + 8'hE3);
      wr(2'd0, 2'b01, 16'(8 + l));
      wr(2'd2, 2'b11, {tm, lc});
      m_lcr[l] = {lc[5], 1'b0, lc[3:0]};
      m_tms[l] = tm[4:0];
      chk("R5 flush pulse", 32'(flush_o), lc[4] ? 32'(1 << l) : 0);
      @(negedge clk);
      chk("R5 flush ends", 32'(flush_o), 0);
      rd(2'd2, d); chk("R6 readback", 32'(d), 32'({3'b0, m_tms[l], 2'b0, m_lcr[l]}));
    end
    check_lines("R6");

    // R7 byte lane isolation on line 3
    wr(2'd0, 2'b01, 16'h000B);
    wr(2'd2, 2'b10, 16'h0AFF);
    m_tms[3] = 5'h0A;
    check_lines("R7 high lane");
    wr(2'd2, 2'b01, 16'h1F2C);
    m_lcr[3] = 6'h2C;
    check_lines("R7 low lane");

    // R4 line parameters
    for (int l = 0; l < N; l++) begin
      logic [15:0] v;
      v = 16'((l*16'h1357 + 16'h2468) & 16'hFFF8) | 16'(l);
      wr(2'd1, 2'b11, v);
      m_lpr[l] = v[15:3];
    end
    wr(2'd1, 2'b01, 16'hFFFA);
    m_lpr[2][4:0] = 5'h1F;
    wr(2'd1, 2'b10, 16'h0006);
    m_lpr[6][12:5] = 8'h00;
    check_lines("R4");
    for (int l = 0; l < N; l++) begin
      wr(2'd0, 2'b01, 16'(l));
      rd(2'd1, d); chk("R4 readback", 32'(d), 32'({m_lpr[l], 3'(l)}));
      // R8 group 0 read
      rd(2'd2, d); chk("R8", 32'(d), 32'({rms_i[l*6 +: 6], 2'b0, tsc_i[l*8 +: 8]}));
    end

    // R9 transmit data strobe
    wr(2'd0, 2'b01, 16'h0004);
    wr(2'd2, 2'b01, 16'h775A);
    chk("R9 valid", 32'(txd_valid_o), 1);
    chk("R9 line", 32'(txd_line_o), 4);
    chk("R9 data", 32'(txd_data_o), 32'h5A);
    @(negedge clk);
    chk("R9 one cycle", 32'(txd_valid_o), 0);
    wr(2'd2, 2'b10, 16'hFF00);
    chk("R9 high only", 32'(txd_valid_o), 0);
    check_lines("R9");

    // R10 groups 2 and 3, R11 offset 3
    wr(2'd0, 2'b01, 16'h0011);
    wr(2'd2, 2'b11, 16'hFFFF);
    rd(2'd2, d); chk("R10 group2", 32'(d), 0);
    chk("R10", 32'({flush_o, txd_valid_o}), 0);
    wr(2'd0, 2'b01, 16'h0019);
    wr(2'd2, 2'b11, 16'hFFFF);
    rd(2'd2, d); chk("R10 group3", 32'(d), 0);
    check_lines("R10");
    wr(2'd3, 2'b11, 16'hFFFF);
    rd(2'd3, d); chk("R11", 32'(d), 0);
    check_lines("R11");

    // R3 master clear
    wr(2'd0, 2'b11, 16'h4069);
    rd(2'd0, d); chk("R3 bit set", 32'(d), 32'h4069);
    check_lines("R3 before");
    @(negedge clk);
    rd(2'd0, d); chk("R3 bit clear", 32'(d), 32'h0009);
    for (int l = 0; l < N; l++) begin m_lcr[l] = 0; m_tms[l] = 0; m_lpr[l] = 0; end
    check_lines("R3 wiped");
    chk("R3 enables", {tx_ie_o, rx_ie_o}, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule